// File: doc/BRIEF.md
# Adaptive FSK Data Slicer

This block turns a stream of signed instantaneous-frequency samples, each qualified by a valid strobe, into hard data decisions. The two tone frequencies rarely sit symmetrically about zero, because the transmitter and receiver carriers disagree. The block therefore learns the decision level from the signal. It tracks the level it currently sits on. A swing of more than half the configured tone spacing counts as a real bit transition. On each such transition it captures the new extreme.

Every transition that completes a high/low pair produces a midpoint. The recent midpoints are averaged over a window of 2, 4, 8 or 16 entries. The sample is sliced against that average. The same average leaves the block as a saturated signed 8-bit frequency-offset estimate. A settled flag reports that the chosen window has filled.

Training normally uses an alternating preamble. Dropping the receive enable discards everything learned.

Top module: `fsk_slicer`

## Requirements
- R1: One cycle after a sample with `smp_valid` high, `bit_out` is 1 when the sample is strictly greater than the current threshold, and 0 otherwise. The threshold used is the one in force before that sample.
- R2: Until the first midpoint has been captured, the threshold is 0.
- R3: The first valid sample after enable only sets the tracked level. After that, a transition happens when a sample exceeds the tracked level by more than `dev_cfg >> 1` (upward, captures a new high) or falls below it by more than `dev_cfg >> 1` (downward, captures a new low). Either kind of transition also moves the tracked level to the sample. A move equal to `dev_cfg >> 1` is not a transition.
- R4: A transition produces a midpoint, (new extreme + opposite extreme) >>> 1 with floor rounding, only once an opposite extreme has been captured.
- R5: While fewer midpoints than the window length have been captured, the threshold is the most recent midpoint.
- R6: Once the window is full, the threshold is the sum of the newest N midpoints, arithmetically shifted right by log2 N. N is set by `avg_sel`: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16. A change of `avg_sel` takes effect immediately on the stored midpoints.
- R7: `settled` is high exactly when the number of captured midpoints (counted up to 16) is at least N.
- R8: `freq_ofs` is the threshold in two's complement, saturated to -128..127.
- R9: While reset is asserted (synchronous, active low) or `rx_en` is low, the next clock edge clears the tracked levels, the stored midpoints and the count. After that edge, `bit_out`, `settled` and `freq_ofs` are all 0.
- R10: A cycle with `smp_valid` low changes neither the tracked state nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receive enable; low clears all learned state |
| smp_valid | input | 1 | Qualifies `smp_freq` |
| smp_freq | input | SMP_W (12) | Signed frequency sample |
| dev_cfg | input | SMP_W (12) | Expected tone spacing, unsigned |
| avg_sel | input | SEL_W (2) | Averaging window select |
| bit_out | output | 1 | Sliced data bit |
| settled | output | 1 | Averaging window full |
| freq_ofs | output | OFS_W (8) | Saturated signed offset estimate |

## Verification
The embedded assertions check the following on every cycle:
- the output bit holds through idle cycles;
- a disabled receiver leaves all outputs cleared;
- midpoints are only taken on valid samples;
- the settled flag stays high, and can only rise on a captured midpoint, while the window setting is unchanged.

The numerical behaviour can only be shown by the bench's scenarios against its own reference model. This covers:
- the exact half-spacing transition boundary;
- the partial-window and full-window threshold values;
- the floor rounding;
- offset saturation at large carrier errors;
- window changes in mid-stream.

// File: rtl/fsk_slicer_pkg.sv
package fsk_slicer_pkg;

    // Averaging window length for a given select code: 2, 4, 8, 16 ...
    function automatic int unsigned win_len(int unsigned sel);
        return 32'd2 << sel;
    endfunction

    // log2 of the window length, used as the arithmetic shift amount
    function automatic int unsigned win_shift(int unsigned sel);
        return sel + 32'd1;
    endfunction

endpackage

// File: rtl/fsk_edge_tracker.sv
module fsk_edge_tracker #(
    parameter int SMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    vld,
    input  logic signed [SMP_W-1:0] smp,
    input  logic        [SMP_W-1:0] half,
    output logic                    push,
    output logic signed [SMP_W-1:0] mid
);
    localparam int XW = SMP_W + 2;

    typedef struct packed {
        logic signed [SMP_W-1:0] lvl;
        logic signed [SMP_W-1:0] hi;
        logic signed [SMP_W-1:0] lo;
        logic                    have_lvl;
        logic                    have_hi;
        logic                    have_lo;
    } trk_t;

    trk_t trk_d, trk_q;

    logic signed [XW-1:0] smp_x, lvl_x, half_x, pair_x, msum_x;
    logic                 up, dn;

    always_comb begin
        smp_x  = XW'(smp);
        lvl_x  = XW'(trk_q.lvl);
        half_x = $signed({2'b00, half});
        up     = trk_q.have_lvl && ((smp_x - lvl_x) > half_x);
        dn     = trk_q.have_lvl && ((lvl_x - smp_x) > half_x);
        pair_x = up ? XW'(trk_q.lo) : XW'(trk_q.hi);
        msum_x = smp_x + pair_x;
        mid    = SMP_W'(msum_x >>> 1);
        push   = vld && !clr && ((up && trk_q.have_lo) || (dn && trk_q.have_hi));

        trk_d = trk_q;
        if (clr) begin
            trk_d = '0;
        end else if (vld) begin
            if (!trk_q.have_lvl) begin
                trk_d.lvl      = smp;
                trk_d.have_lvl = 1'b1;
            end else if (up) begin
                trk_d.lvl     = smp;
                trk_d.hi      = smp;
                trk_d.have_hi = 1'b1;
            end else if (dn) begin
                trk_d.lvl     = smp;
                trk_d.lo      = smp;
                trk_d.have_lo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // Tracked level moves only on a valid sample (R3, R10)
    assert_level_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !clr) |=> $stable(trk_q.lvl));

endmodule

// File: rtl/fsk_mid_window.sv
module fsk_mid_window #(
    parameter int SMP_W = 12,
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic signed [SMP_W-1:0] mid,
    input  logic        [SEL_W-1:0] sel,
    output logic signed [SMP_W-1:0] thr,
    output logic                    full
);
    import fsk_slicer_pkg::*;

    localparam int WIN_MAX = 2 << ((1 << SEL_W) - 1);
    localparam int AW      = $clog2(WIN_MAX);
    localparam int CNT_W   = AW + 1;
    localparam int SUM_W   = SMP_W + AW;

    typedef struct packed {
        logic [WIN_MAX-1:0][SMP_W-1:0] slot;
        logic [AW-1:0]                 wp;
        logic [CNT_W-1:0]              cnt;
    } win_t;

    win_t win_d, win_q;

    logic        [CNT_W-1:0] n_sel;
    logic        [SEL_W:0]   shamt;
    logic        [AW-1:0]    last;
    logic signed [SUM_W-1:0] term [WIN_MAX];
    logic signed [SUM_W-1:0] sum;

    assign n_sel = CNT_W'(win_len(int'(sel)));
    assign shamt = (SEL_W+1)'(win_shift(int'(sel)));
    assign last  = win_q.wp - AW'(1);

    for (genvar i = 0; i < WIN_MAX; i++) begin : g_term
        logic [AW-1:0] idx;
        assign idx     = win_q.wp - AW'(i + 1);
        assign term[i] = (CNT_W'(i) < n_sel) ? SUM_W'($signed(win_q.slot[idx])) : '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < WIN_MAX; k++) sum = sum + term[k];
    end

    always_comb begin
        full = (win_q.cnt >= n_sel);
        if (full)                 thr = SMP_W'(sum >>> shamt);
        else if (win_q.cnt != '0) thr = $signed(win_q.slot[last]);
        else                      thr = '0;

        win_d = win_q;
        if (clr) begin
            win_d.wp  = '0;
            win_d.cnt = '0;
        end else if (push) begin
            win_d.slot[win_q.wp] = mid;
            win_d.wp             = win_q.wp + AW'(1);
            if (win_q.cnt != CNT_W'(WIN_MAX)) win_d.cnt = win_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // Full window stays full while the setting holds (R7)
    assert_settle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> (full || (sel != $past(sel))));

    // Window can only become full on a captured midpoint (R7)
    assert_settle_on_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(full) && $stable(sel)) |-> $past(push));

endmodule

// File: rtl/fsk_slicer.sv
module fsk_slicer #(
    parameter int SMP_W = 12,
    parameter int SEL_W = 2,
    parameter int OFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_freq,
    input  logic        [SMP_W-1:0] dev_cfg,
    input  logic        [SEL_W-1:0] avg_sel,
    output logic                    bit_out,
    output logic                    settled,
    output logic signed [OFS_W-1:0] freq_ofs
);
    localparam logic signed [SMP_W-1:0] OFS_HI = SMP_W'((1 << (OFS_W - 1)) - 1);
    localparam logic signed [SMP_W-1:0] OFS_LO = SMP_W'(-(1 << (OFS_W - 1)));

    logic                    clr;
    logic        [SMP_W-1:0] half;
    logic                    push;
    logic signed [SMP_W-1:0] mid;
    logic signed [SMP_W-1:0] thr;
    logic                    full;
    logic                    bit_d, bit_q;

    assign clr  = !rx_en;
    assign half = dev_cfg >> 1;

    fsk_edge_tracker #(.SMP_W(SMP_W)) i_tracker (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .vld  (smp_valid),
        .smp  (smp_freq),
        .half (half),
        .push (push),
        .mid  (mid)
    );

    fsk_mid_window #(.SMP_W(SMP_W), .SEL_W(SEL_W)) i_window (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .push (push),
        .mid  (mid),
        .sel  (avg_sel),
        .thr  (thr),
        .full (full)
    );

    always_comb begin
        bit_d = bit_q;
        if (clr)            bit_d = 1'b0;
        else if (smp_valid) bit_d = (smp_freq > thr);

        if (thr > OFS_HI)      freq_ofs = OFS_W'(OFS_HI);
        else if (thr < OFS_LO) freq_ofs = OFS_W'(OFS_LO);
        else                   freq_ofs = OFS_W'(thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign bit_out = bit_q;
    assign settled = full;

    // Idle cycles leave the decision untouched (R10)
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !smp_valid) |=> $stable(bit_out));

    // Disabling reception clears every output (R9)
    assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!bit_out && !settled && (freq_ofs == '0)));

    // Midpoints are only captured from a valid enabled sample (R4)
    assert_push_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (smp_valid && rx_en));

endmodule

// File: tb/test_fsk_slicer.sv
module test_fsk_slicer;
    logic              clk = 1'b0;
    logic              rst_n, rx_en, smp_valid;
    logic signed [11:0] smp_freq;
    logic        [11:0] dev_cfg;
    logic        [1:0]  avg_sel;
    logic              bit_out, settled;
    logic signed [7:0]  freq_ofs;

    always #2 clk = ~clk;

    fsk_slicer i_fsk_slicer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
        .smp_freq(smp_freq), .dev_cfg(dev_cfg), .avg_sel(avg_sel),
        .bit_out(bit_out), .settled(settled), .freq_ofs(freq_ofs)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int lvl_m, hi_m, lo_m;
    bit have_lvl, have_hi, have_lo;
    int mids[$];
    int cnt_m;
    bit e_bit;

    function automatic int m_thr();
        int n = 2 << avg_sel;
        int s = 0;
        if (cnt_m >= n) begin
            for (int i = 0; i < n; i++) s += mids[i];
            return s >>> (avg_sel + 1);
        end
        if (cnt_m > 0) return mids[0];
        return 0;
    endfunction

    function automatic int m_sat(int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic m_clear();
        have_lvl = 0; have_hi = 0; have_lo = 0;
        lvl_m = 0; hi_m = 0; lo_m = 0;
        mids.delete(); cnt_m = 0; e_bit = 0;
    endtask

    task automatic m_push(int v);
        mids.push_front(v);
        if (mids.size() > 16) void'(mids.pop_back());
        if (cnt_m < 16) cnt_m++;
    endtask

    task automatic m_update(int s);
        int half = int'(dev_cfg) >>> 1;
        if (!have_lvl) begin
            lvl_m = s; have_lvl = 1;
        end else if (s - lvl_m > half) begin
            hi_m = s; lvl_m = s; have_hi = 1;
            if (have_lo) m_push((s + lo_m) >>> 1);
        end else if (lvl_m - s > half) begin
            lo_m = s; lvl_m = s; have_lo = 1;
            if (have_hi) m_push((s + hi_m) >>> 1);
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        chk({tag, " R1 bit_out"}, int'(bit_out), int'(e_bit));
        chk({tag, " R7 settled"}, int'(settled), (cnt_m >= (2 << avg_sel)) ? 1 : 0);
        chk({tag, " R8 freq_ofs"}, int'(freq_ofs), m_sat(m_thr()));
    endtask

    // one clock: drive, let the edge pass, update model, check
    task automatic step(bit v, int s, string tag);
        bit nb;
        smp_valid = v;
        smp_freq  = 12'(s);
        nb = (s > m_thr());
        @(posedge clk);
        #1;
        if (!rx_en) m_clear();
        else if (v) begin
            e_bit = nb;
            m_update(s);
        end
        check_outs(tag);
    endtask

    task automatic run_tones(int center, int dev, int nsym, bit rand_data, string tag);
        for (int k = 0; k < nsym; k++) begin
            bit b = rand_data ? bit'($urandom % 2) : bit'(k % 2);
            int reps = 1 + int'($urandom % 2);
            for (int r = 0; r < reps; r++) begin
                int nz = int'($urandom % (dev / 4 + 1)) - dev / 8;
                int s  = center + (b ? dev / 2 : -(dev / 2)) + nz;
                if ($urandom % 5 == 0) step(0, int'($urandom % 1000) - 500, "R10 idle gap");
                step(1, s, tag);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int centers[6] = '{0, 37, -90, 500, -700, 260};
        void'($urandom(32'd20240611));
        rst_n = 0; rx_en = 0; smp_valid = 0; smp_freq = '0;
        dev_cfg = 12'd200; avg_sel = 2'd0;
        m_clear();
        repeat (3) @(posedge clk);
        #1;
        check_outs("R9 reset state");
        rst_n = 1;
        rx_en = 1;

        // directed: transition boundary and first midpoints
        step(1, 100,  "R3 first sample only sets level, R2 zero threshold");
        step(1, 0,    "R3 move equal to half is no transition");
        step(1, -1,   "R3 move past half captures low");
        step(1, 205,  "R4 first midpoint");
        step(0, 900,  "R10 invalid sample ignored");
        step(0, -900, "R10 invalid sample ignored");
        step(1, -3,   "R6 window of two full");
        step(1, 40,   "R5 R6 inside band");

        // directed: rounding with negative odd sum
        rx_en = 0; step(0, 0, "R9 disable clears");
        rx_en = 1; avg_sel = 2'd1;
        step(1, -50, "R3 level set");
        step(1, -300, "R3 low captured");
        step(1, -45, "R4 floor rounding midpoint");
        step(1, -301, "R5 partial window");

        // random tone scenarios over all window sizes and offsets
        for (int sc = 0; sc < 24; sc++) begin
            rx_en   = 0;
            step(0, 0, "R9 disable between runs");
            rx_en   = 1;
            avg_sel = 2'(sc % 4);
            dev_cfg = 12'(120 + int'($urandom % 200));
            run_tones(centers[sc % 6], int'(dev_cfg), 16, 0, "R6 preamble training");
            if (sc % 3 == 1) avg_sel = 2'($urandom % 4);
            run_tones(centers[sc % 6] + int'($urandom % 20) - 10, int'(dev_cfg), 40, 1,
                      "R6 random data");
        end

        // unconstrained samples and spacings, including zero spacing
        for (int sc = 0; sc < 8; sc++) begin
            dev_cfg = 12'($urandom % 256);
            for (int k = 0; k < 150; k++) begin
                if ($urandom % 40 == 0) rx_en = 0;
                else rx_en = 1;
                if ($urandom % 30 == 0) avg_sel = 2'($urandom % 4);
                step(bit'($urandom % 4 != 0), int'($urandom % 1600) - 800, "R3 R9 stress");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule